// File: doc/BRIEF.md
# Pipelined SPI Register Frame Engine

This block runs register reads and writes against a sensor over SPI on behalf of a host. Each request carries a 7-bit register address, a direction, a width flag (16 or 32 bits) and write data. The engine turns the request into a short train of 32-bit command frames. It shifts each frame out as a single word per chip-select in SPI mode 3. It then checks the frames that come back and returns the read data together with three sticky error flags.

The sensor answers each command one frame later, so the engine always sends one more frame than there are halves to move. That last frame repeats the final command so that the final reply can be collected. The reply that arrives during the first frame of a request belongs to whatever was sent before, and the engine discards it. A 32-bit access is split into two 16-bit halves. The upper half is sent to the next register up, then the lower half goes to the base register. Every reply is checked for its 4-bit checksum and its 2-bit status field. On writes the echoed data is compared with what was written. One command register is exempt from that comparison, because it does not echo.

Requests enter through a valid/ready handshake. `req_ready` is high only while the engine is idle, so a request that is offered while a sequence is running waits, with its fields held, until the engine returns to idle. Results leave without back-pressure: `done` pulses for one cycle, and `rd_data` and the error flags are valid from that cycle until the next request is accepted.

Top module: `sreg_frame_engine`

## Requirements
- R1: A command frame carries data in bits 31:16, the register address in bits 14:8, the write flag in bit 7 and the checksum in bits 3:0. Bits 15 and 6:4 are zero. On a read, the data field and the write flag are zero.
- R2: The frame checksum is 0xA XORed with the seven nibbles of bits 31:4, starting from bits 31:28. The same rule is used to build commands and to verify replies.
- R3: A 16-bit request sends exactly two frames. Both frames are the command for the base address.
- R4: A 32-bit request sends exactly three frames: the upper-half command to address+1 (wrapping modulo 128), the lower-half command to the base address, and that lower-half command again. Write data bits 31:16 go with the upper half.
- R5: The serial port works in SPI mode 3, most significant bit first. `spi_sclk` rests high whenever `spi_cs_n` is high. MOSI changes only on falling clock edges and MISO is sampled on rising edges. `spi_cs_n` is low for exactly one 32-bit word and stays high for at least GAP_CYC cycles between words.
- R6: The reply received during the first frame of a request is ignored. It affects neither the data nor any error flag.
- R7: Read data is taken from bits 31:16 of the checked replies. A 16-bit request returns it zero-extended. A 32-bit request returns {upper reply, lower reply}. `rd_data` changes only in the cycle in which `done` is high.
- R8: `err_crc` is set when any checked reply has bits 3:0 unequal to the checksum of its own bits 31:4.
- R9: `err_status` is set when any checked reply has a status field (bits 7:6) of 2 or 3. Values 0 and 1 leave it clear.
- R10: On a write, `err_wrback` is set when the echoed bits 31:16 of a checked reply differ from the half that was written. When the base address equals CMD_REG (default 0x50), no half is compared. Reads never set it.
- R11: `req_ready` is high exactly when idle. `done` is a one-cycle pulse. The three error flags accumulate over one request, are valid when `done` rises, and clear on the cycle after the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_addr | input | 7 | Base register address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit access, 0 = 16-bit |
| req_wdata | input | 32 | Write data (bits 15:0 only for 16-bit) |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 32 | Returned data, valid from `done` |
| err_crc | output | 1 | Sticky reply checksum error |
| err_status | output | 1 | Sticky bad status error |
| err_wrback | output | 1 | Sticky write readback mismatch |
| spi_sclk | output | 1 | Serial clock, idle high |
| spi_cs_n | output | 1 | Chip-select, active low |
| spi_mosi | output | 1 | Serial data to the sensor |
| spi_miso | input | 1 | Serial data from the sensor |

## Verification
The properties assume that a request holds its fields stable while it is offered. They also assume that `spi_miso` is settled before each rising serial clock edge, which makes the sampled reply well defined, and that HALF_CYC and GAP_CYC are at least 1. The bench drives requests only on falling system-clock edges and drops `req_valid` right after acceptance. Its sensor model updates MISO only after it sees a falling serial clock, and it runs the port at the smallest half-period so that this settling margin is exercised at its tightest. Fault injection damages only the reply frames themselves (checksum, status, echoed data), never the handshake, so the protocol assumptions hold throughout every error case.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

  localparam int FRAME_W = 32;
  localparam int ADDR_W  = 7;
  localparam int HALF_W  = 16;

  typedef enum logic [2:0] {W_IDLE, W_LEAD, W_SHIFT, W_TAIL, W_GAP} wire_state_e;
  typedef enum logic [1:0] {Q_IDLE, Q_LAUNCH, Q_WAIT, Q_FINISH} seq_state_e;

  // nibble-XOR check over bits 31:4, seeded with 0xA, top nibble first
  function automatic logic [3:0] nib_sum(input logic [FRAME_W-1:0] w);
    logic [3:0] s;
    s = 4'hA;
    for (int i = FRAME_W/4 - 1; i >= 1; i--) s = s ^ w[i*4 +: 4];
    return s;
  endfunction

  function automatic logic [FRAME_W-1:0] build_cmd(input logic [ADDR_W-1:0] a,
                                                   input logic wr,
                                                   input logic [HALF_W-1:0] d);
    logic [FRAME_W-1:0] w;
    w = {(wr ? d : {HALF_W{1'b0}}), 1'b0, a, wr, 7'h00};
    w[3:0] = nib_sum(w);
    return w;
  endfunction

endpackage

// File: rtl/sfe_spi_word.sv
module sfe_spi_word
  import sfe_pkg::*;
#(
  parameter int HALF_CYC = 2,
  parameter int GAP_CYC  = 4,
  parameter int WORD_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] tx_word,
  output logic              fin,
  output logic [WORD_W-1:0] rx_word,
  output logic              sclk,
  output logic              cs_n,
  output logic              mosi,
  input  logic              miso
);
  localparam int SPAN  = (HALF_CYC > GAP_CYC) ? HALF_CYC : GAP_CYC;
  localparam int CNT_W = $clog2(SPAN + 1);
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] HALF_END = CNT_W'(HALF_CYC - 1);
  localparam logic [CNT_W-1:0] GAP_END  = CNT_W'(GAP_CYC - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  wire_state_e       st;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= W_IDLE;
      cnt     <= '0;
      bit_cnt <= '0;
      tx_sh   <= '0;
      rx_word <= '0;
      sclk    <= 1'b1;
      cs_n    <= 1'b1;
      mosi    <= 1'b0;
      fin     <= 1'b0;
    end else begin
      fin <= 1'b0;
      case (st)
        W_IDLE: if (start) begin
          tx_sh <= tx_word;
          cs_n  <= 1'b0;
          cnt   <= '0;
          st    <= W_LEAD;
        end
        W_LEAD: begin
          if (cnt == HALF_END) begin
            cnt     <= '0;
            bit_cnt <= '0;
            st      <= W_SHIFT;
          end else cnt <= cnt + 1'b1;
        end
        W_SHIFT: begin
          if (cnt == HALF_END) begin
            cnt <= '0;
            if (sclk) begin
              sclk  <= 1'b0;                 // falling edge: present next bit
              mosi  <= tx_sh[WORD_W-1];
              tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
            end else begin
              sclk    <= 1'b1;               // rising edge: capture reply bit
              rx_word <= {rx_word[WORD_W-2:0], miso};
              if (bit_cnt == LAST_BIT) st <= W_TAIL;
              else bit_cnt <= bit_cnt + 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        W_TAIL: begin
          if (cnt == HALF_END) begin
            cnt  <= '0;
            cs_n <= 1'b1;
            st   <= W_GAP;
          end else cnt <= cnt + 1'b1;
        end
        W_GAP: begin
          if (cnt == GAP_END) begin
            cnt <= '0;
            fin <= 1'b1;
            st  <= W_IDLE;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfe_reply_check.sv
module sfe_reply_check
  import sfe_pkg::*;
(
  input  logic [FRAME_W-1:0] word,
  input  logic [HALF_W-1:0]  expect_data,
  input  logic               check_write,
  output logic [HALF_W-1:0]  data,
  output logic               crc_bad,
  output logic               sv_bad,
  output logic               wr_bad
);
  always_comb begin
    data    = word[FRAME_W-1 -: HALF_W];
    crc_bad = (word[3:0] != nib_sum(word));
    sv_bad  = (word[7:6] >= 2'd2);
    wr_bad  = check_write && (data != expect_data);
  end
endmodule

// File: rtl/sreg_frame_engine.sv
module sreg_frame_engine
  import sfe_pkg::*;
#(
  parameter int              HALF_CYC = 2,
  parameter int              GAP_CYC  = 4,
  parameter logic [6:0]      CMD_REG  = 7'h50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [6:0]  req_addr,
  input  logic        req_write,
  input  logic        req_wide,
  input  logic [31:0] req_wdata,
  output logic        done,
  output logic [31:0] rd_data,
  output logic        err_crc,
  output logic        err_status,
  output logic        err_wrback,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam logic [1:0] LAST_WIDE   = 2'd2;
  localparam logic [1:0] LAST_NARROW = 2'd1;

  seq_state_e          st;
  logic [ADDR_W-1:0]   addr_q;
  logic                wr_q, wide_q;
  logic [FRAME_W-1:0]  wdata_q;
  logic [1:0]          fidx;
  logic [HALF_W-1:0]   hi_q, lo_q;
  logic                fin;
  logic [FRAME_W-1:0]  tx_word, rx_word;
  logic [HALF_W-1:0]   rep_data, exp_half;
  logic                crc_bad, sv_bad, wr_bad;
  logic                send_hi, rep_hi, accept;
  logic [1:0]          last_idx;
  logic [ADDR_W-1:0]   tx_addr;

  assign req_ready = (st == Q_IDLE);
  assign accept    = req_valid && req_ready;
  assign last_idx  = wide_q ? LAST_WIDE : LAST_NARROW;
  assign send_hi   = wide_q && (fidx == 2'd0);
  assign rep_hi    = wide_q && (fidx == 2'd1);
  assign tx_addr   = send_hi ? addr_q + 7'd1 : addr_q;
  assign tx_word   = build_cmd(tx_addr, wr_q, send_hi ? wdata_q[31:16] : wdata_q[15:0]);
  assign exp_half  = rep_hi ? wdata_q[31:16] : wdata_q[15:0];

  sfe_spi_word #(.HALF_CYC(HALF_CYC), .GAP_CYC(GAP_CYC), .WORD_W(FRAME_W)) u_wire (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (st == Q_LAUNCH),
    .tx_word (tx_word),
    .fin     (fin),
    .rx_word (rx_word),
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .mosi    (spi_mosi),
    .miso    (spi_miso)
  );

  sfe_reply_check u_check (
    .word        (rx_word),
    .expect_data (exp_half),
    .check_write (wr_q && (addr_q != CMD_REG)),
    .data        (rep_data),
    .crc_bad     (crc_bad),
    .sv_bad      (sv_bad),
    .wr_bad      (wr_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= Q_IDLE;
      addr_q     <= '0;
      wr_q       <= 1'b0;
      wide_q     <= 1'b0;
      wdata_q    <= '0;
      fidx       <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      done       <= 1'b0;
      rd_data    <= '0;
      err_crc    <= 1'b0;
      err_status <= 1'b0;
      err_wrback <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        Q_IDLE: if (accept) begin
          addr_q     <= req_addr;
          wr_q       <= req_write;
          wide_q     <= req_wide;
          wdata_q    <= req_wdata;
          fidx       <= '0;
          err_crc    <= 1'b0;
          err_status <= 1'b0;
          err_wrback <= 1'b0;
          st         <= Q_LAUNCH;
        end
        Q_LAUNCH: st <= Q_WAIT;
        Q_WAIT: if (fin) begin
          if (fidx != 2'd0) begin      // frame 0 carries a stale reply
            err_crc    <= err_crc    | crc_bad;
            err_status <= err_status | sv_bad;
            err_wrback <= err_wrback | wr_bad;
            if (rep_hi) hi_q <= rep_data;
            else        lo_q <= rep_data;
          end
          if (fidx == last_idx) st <= Q_FINISH;
          else begin
            fidx <= fidx + 2'd1;
            st   <= Q_LAUNCH;
          end
        end
        Q_FINISH: begin
          done    <= 1'b1;
          rd_data <= wide_q ? {hi_q, lo_q} : {16'h0000, lo_q};
          st      <= Q_IDLE;
        end
        default: st <= Q_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfe_assert.sv
module sfe_assert #(
  parameter int GAP_CYC = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        done,
  input logic [31:0] rd_data,
  input logic        err_crc,
  input logic        err_status,
  input logic        err_wrback,
  input logic        spi_sclk,
  input logic        spi_cs_n,
  input logic        spi_mosi
);
  logic [15:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap_cnt <= 16'hFFFF;
    else if (!spi_cs_n) gap_cnt <= '0;
    else if (gap_cnt != 16'hFFFF) gap_cnt <= gap_cnt + 16'd1;
  end

  // R5
  sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_sclk);

  // R5
  mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  // R5
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (gap_cnt >= 16'(GAP_CYC)));

  // R11
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !spi_cs_n |-> !req_ready);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done);

  // R11
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(err_crc) || $fell(err_status) || $fell(err_wrback))
      |-> $past(req_valid && req_ready));
endmodule

bind sreg_frame_engine sfe_assert #(.GAP_CYC(GAP_CYC)) u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .done       (done),
  .rd_data    (rd_data),
  .err_crc    (err_crc),
  .err_status (err_status),
  .err_wrback (err_wrback),
  .spi_sclk   (spi_sclk),
  .spi_cs_n   (spi_cs_n),
  .spi_mosi   (spi_mosi)
);

// File: tb/sreg_frame_engine_test.sv
`timescale 1ns/1ps
module sreg_frame_engine_test;
  localparam int         HALF = 1;
  localparam int         GAP  = 2;
  localparam logic [6:0] CMD  = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_wide = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, done, err_crc, err_status, err_wrback;
  logic [31:0] rd_data;
  logic spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  always #2.5 clk = ~clk;

  sreg_frame_engine #(.HALF_CYC(HALF), .GAP_CYC(GAP), .CMD_REG(CMD)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_wide(req_wide),
    .req_wdata(req_wdata), .done(done), .rd_data(rd_data), .err_crc(err_crc),
    .err_status(err_status), .err_wrback(err_wrback), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  int n_chk = 0, n_err = 0, cyc = 0;

  function automatic logic [3:0] xsum(input logic [31:0] w);
    logic [3:0] s = 4'hA;
    for (int k = 28; k >= 4; k -= 4) s ^= w[k +: 4];
    return s;
  endfunction
  function automatic logic [31:0] cmd_word(input logic [6:0] a, input logic wr, input logic [15:0] d);
    logic [31:0] w = {wr ? d : 16'h0, 1'b0, a, wr, 7'h00};
    w[3:0] = xsum(w);
    return w;
  endfunction
  function automatic logic [31:0] rep_word(input logic [15:0] d, input logic [6:0] a, input logic [1:0] sv);
    logic [31:0] w = {d, 1'b0, a, sv, 6'h00};
    w[3:0] = xsum(w);
    return w;
  endfunction
  function automatic logic [15:0] pat16(input int a);
    return 16'(a * 613) ^ 16'h3C5A;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // sensor model: pipelined replies, command register does not echo
  logic [15:0] mem [0:127];
  logic [31:0] cap [0:2047];
  int fcount = 0;
  int inj_crc_at = -1, inj_sv_at = -1, inj_wr_at = -1;
  logic [1:0]  inj_sv_val = 2'd0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  logic [31:0] sh_in = '0, sh_out = '0;
  logic [15:0] nxt_d = '0;
  logic [6:0]  nxt_a = '0;

  always @(negedge clk) begin : slave
    logic [15:0] d;
    logic [1:0]  sv;
    if (!rst_n) begin
      for (int k = 0; k < 128; k++) mem[k] = 16'h0000;
    end else begin
      if (prev_cs && !spi_cs_n) begin
        d  = nxt_d ^ ((fcount == inj_wr_at) ? 16'h0100 : 16'h0000);
        sv = (fcount == inj_sv_at) ? inj_sv_val : 2'd1;
        sh_out = rep_word(d, nxt_a, sv);
        if (fcount == inj_crc_at) sh_out[3:0] = sh_out[3:0] ^ 4'h1;
      end
      if (!spi_cs_n && prev_sclk && !spi_sclk) begin
        spi_miso = sh_out[31];
        sh_out   = {sh_out[30:0], 1'b0};
      end
      if (!spi_cs_n && !prev_sclk && spi_sclk) sh_in = {sh_in[30:0], spi_mosi};
      if (!prev_cs && spi_cs_n) begin
        cap[fcount] = sh_in;
        if (sh_in[7]) begin
          mem[sh_in[14:8]] = sh_in[31:16];
          nxt_d = (sh_in[14:8] == CMD) ? 16'h0000 : sh_in[31:16];
        end else nxt_d = mem[sh_in[14:8]];
        nxt_a = sh_in[14:8];
        fcount++;
      end
    end
    prev_cs   = spi_cs_n;
    prev_sclk = spi_sclk;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_err++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // issues one request, waits for done and checks the frames sent (R1 R2 R3 R4 R5)
  task automatic run_req(input logic [6:0] a, input logic wr, input logic wide, input logic [31:0] wd);
    int start = fcount;
    int nfr = wide ? 3 : 2;
    int waited = 0;
    logic [6:0] ahi = a + 7'd1;
    logic [31:0] exp;
    @(negedge clk);
    req_addr = a; req_write = wr; req_wide = wide; req_wdata = wd; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done && waited < 4000) begin
      @(negedge clk);
      waited++;
    end
    check("R11 done pulse", {31'd0, done}, 32'd1);
    check(wide ? "R4 frame count" : "R3 frame count", 32'(fcount - start), 32'(nfr));
    for (int i = 0; i < nfr; i++) begin
      exp = (wide && i == 0) ? cmd_word(ahi, wr, wd[31:16]) : cmd_word(a, wr, wd[15:0]);
      check(wide ? "R1 R2 R4 R5 frame" : "R1 R2 R3 R5 frame", cap[start + i], exp);
    end
  endtask

  task automatic flags(input string tag, input logic [2:0] exp);
    check(tag, {29'd0, err_crc, err_status, err_wrback}, {29'd0, exp});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R11 reset ready", {31'd0, req_ready}, 32'd1);
    check("R11 reset done/flags", {28'd0, done, err_crc, err_status, err_wrback}, 32'd0);
    check("R5 reset idle pins", {30'd0, spi_cs_n, spi_sclk}, 32'd3);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // narrow sweep over every address: write then read
    for (int a = 0; a < 128; a++) begin
      logic [15:0] v = pat16(a);
      run_req(7'(a), 1'b1, 1'b0, {16'h0, v});
      check("R10 narrow write echo", rd_data, {16'h0, (7'(a) == CMD) ? 16'h0 : v});
      flags("R10 narrow write flags", 3'b000);
      run_req(7'(a), 1'b0, 1'b0, 32'h0);
      check("R7 narrow read data", rd_data, {16'h0, v});
      flags("R8 R9 narrow read flags", 3'b000);
    end

    // wide sweep, including the address wrap at 0x7F and the upper half landing on CMD
    for (int a = 7; a < 128; a += 8) begin
      logic [6:0]  b  = 7'(a);
      logic [6:0]  bh = b + 7'd1;
      logic [15:0] hi = pat16(a + 300), lo = pat16(a + 700);
      logic [15:0] hrb = (bh == CMD) ? 16'h0 : hi;
      logic [15:0] lrb = (b == CMD) ? 16'h0 : lo;
      run_req(b, 1'b1, 1'b1, {hi, lo});
      check("R4 wide write echo", rd_data, {hrb, lrb});
      flags("R10 wide write flags", {2'b00, (b != CMD) && ((hrb != hi) || (lrb != lo))});
      run_req(b, 1'b0, 1'b1, 32'h0);
      check("R7 wide read data", rd_data, {hi, lo});
      flags("R8 R9 wide read flags", 3'b000);
    end

    // checksum error on the checked reply
    inj_crc_at = fcount + 1;
    run_req(7'd5, 1'b0, 1'b0, 32'h0);
    flags("R8 crc flag", 3'b100);
    inj_crc_at = -1;
    // sticky bits clear on next accept
    run_req(7'd5, 1'b0, 1'b0, 32'h0);
    flags("R11 flags cleared", 3'b000);
    // stale first reply is ignored even when corrupt
    inj_crc_at = fcount; inj_sv_at = fcount; inj_sv_val = 2'd3; inj_wr_at = fcount;
    run_req(7'd5, 1'b1, 1'b0, {16'h0, pat16(5)});
    flags("R6 stale reply ignored", 3'b000);
    check("R6 stale reply data", rd_data, {16'h0, pat16(5)});
    inj_crc_at = -1; inj_wr_at = -1;
    // status field values
    for (int s = 0; s < 4; s++) begin
      inj_sv_at = fcount + 1; inj_sv_val = 2'(s);
      run_req(7'd6, 1'b0, 1'b0, 32'h0);
      flags("R9 status field", {1'b0, s >= 2, 1'b0});
    end
    inj_sv_at = -1;
    // readback mismatch on narrow write, both wide halves, and a read
    inj_wr_at = fcount + 1;
    run_req(7'd9, 1'b1, 1'b0, 32'h0000_1234);
    flags("R10 narrow mismatch", 3'b001);
    inj_wr_at = fcount + 1;
    run_req(7'd10, 1'b1, 1'b1, 32'hBEEF_0042);
    flags("R10 wide upper mismatch", 3'b001);
    inj_wr_at = fcount + 2;
    run_req(7'd10, 1'b1, 1'b1, 32'hBEEF_0042);
    flags("R10 wide lower mismatch", 3'b001);
    inj_wr_at = fcount + 1;
    run_req(7'd10, 1'b0, 1'b0, 32'h0);
    flags("R10 read not compared", 3'b000);
    check("R7 read returns echo", rd_data, {16'h0, 16'h0042 ^ 16'h0100});
    inj_wr_at = fcount + 1;
    run_req(CMD, 1'b1, 1'b0, 32'h0000_8000);
    flags("R10 command register exempt", 3'b000);
    inj_wr_at = -1;
    // checksum error on the last wide reply
    inj_crc_at = fcount + 2;
    run_req(7'd20, 1'b0, 1'b1, 32'h0);
    flags("R8 wide crc flag", 3'b100);
    inj_crc_at = -1;

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule